// File: doc/BRIEF.md
# PHY DLL Lock Sequencer

This block brings up the delay-locked loop of a memory PHY after reset. On a go request it loads the start-point and increment fields and switches the DLL on. One cycle later, with the DLL still on, it raises the start control. It then waits until the coarse-lock and fine-lock flags are both high.

Once lock is seen, the block either leaves the DLL running so that it keeps tracking voltage and temperature drift, or it freezes the delay. The freeze happens only when fixed-delay mode is requested and the low-frequency input is set. To freeze, it copies bits [9:2] of the lock value into the force field and then turns the DLL off. A resync pulse of programmable length follows, to push the new delay information to the PHY. A one-cycle done pulse closes the sequence.

If lock does not arrive within a programmable number of cycles, the block raises a sticky error and stops. Only a reset clears that error. After a completed sequence the control outputs stay where they are, and a later go request runs the whole sequence again.

Top module: `dll_lock_seq`

## Requirements
- R1: A go request sampled high while idle or after a completed sequence makes, one cycle later, dll_on_o = 1 and start_o = 0. In that same cycle start_point_o and inc_o show the values present at the go edge, and force_o is 0.
- R2: One cycle after R1, start_o rises while dll_on_o stays 1. Both then stay 1 for the whole lock wait.
- R3: Lock is taken at the first clock edge in the wait at which coarse_lock_i and fine_lock_i are both 1. With only one of them high, the block keeps waiting.
- R4: When fixed_mode_i and low_freq_i are both 1 at the lock edge, force_o equals lock_value_i[9:2] one cycle after lock, with dll_on_o still 1. In the next cycle dll_on_o drops to 0 and stays 0.
- R5: When fixed_mode_i or low_freq_i is 0 at the lock edge, force_o stays 0 and dll_on_o stays 1 after the sequence completes.
- R6: resync_o is 1 for exactly RESYNC_CYC cycles. It begins one cycle after lock in running mode, and two cycles after lock in fixed-delay mode.
- R7: done_o is 1 for exactly one cycle, in the cycle right after resync_o falls.
- R8: A go request is ignored while a sequence is in progress or after an error. Neither the field outputs nor the progress of the sequence change.
- R9: If both lock flags are not seen high within LOCK_TIMEOUT sampled wait cycles, error_o becomes 1 and dll_on_o, start_o and resync_o become 0. This holds until reset.
- R10: While rst_ni is 0, and right after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Request to run the bring-up sequence |
| fixed_mode_i | input | 1 | Request fixed-delay mode after lock |
| low_freq_i | input | 1 | Low-frequency operation; required for fixed-delay mode |
| start_point_i | input | SP_W | Start-point value to load |
| inc_i | input | INC_W | Increment value to load |
| coarse_lock_i | input | 1 | Coarse lock flag from the DLL |
| fine_lock_i | input | 1 | Fine lock flag from the DLL |
| lock_value_i | input | LOCK_W | Delay value reported by the DLL |
| start_point_o | output | SP_W | Start-point control field |
| inc_o | output | INC_W | Increment control field |
| dll_on_o | output | 1 | DLL enable |
| start_o | output | 1 | DLL start |
| force_o | output | LOCK_W-2 | Forced delay value |
| resync_o | output | 1 | Resync pulse |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Sticky lock timeout error |

## Verification
If go is sampled at edge k, dll_on and the field outputs are due after edge k, start after edge k+1, and the wait begins at edge k+2. A lock seen at wait edge k+2+j puts the forced value out one cycle later (in fixed-delay mode), and the resync window starts after it. Done appears RESYNC_CYC cycles after resync first rises, and a timeout error appears right after wait edge k+2+LOCK_TIMEOUT. The bench drives the lock flags from a per-cycle stub and walks the same timeline edge by edge, sampling every output on the falling edge that follows the edge where it is due.

// File: rtl/dll_seq_pkg.sv
`timescale 1ns/1ps
package dll_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EN,
    ST_START,
    ST_WAIT,
    ST_FORCE,
    ST_RESYNC,
    ST_DONE,
    ST_LOCKED,
    ST_ERR
  } seq_st_e;
endpackage

// File: rtl/dll_seq_cnt.sv
`timescale 1ns/1ps
module dll_seq_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (en_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dll_seq_fsm.sv
`timescale 1ns/1ps
module dll_seq_fsm
  import dll_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    go_i,
  input  logic    coarse_i,
  input  logic    fine_i,
  input  logic    freeze_i,
  input  logic    to_hit_i,
  input  logic    rs_hit_i,
  output seq_st_e st_o,
  output logic    frz_o,
  output logic    ld_fields_o,
  output logic    ld_force_o
);
  seq_st_e st_q, st_d;
  logic    frz_q;
  logic    locked;

  assign locked      = coarse_i && fine_i;
  assign ld_fields_o = ((st_q == ST_IDLE) || (st_q == ST_LOCKED)) && go_i;
  assign ld_force_o  = (st_q == ST_WAIT) && locked && freeze_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_LOCKED: if (go_i) st_d = ST_EN;
      ST_EN:     st_d = ST_START;
      ST_START:  st_d = ST_WAIT;
      ST_WAIT: begin
        if (locked)        st_d = freeze_i ? ST_FORCE : ST_RESYNC;
        else if (to_hit_i) st_d = ST_ERR;
      end
      ST_FORCE:  st_d = ST_RESYNC;
      ST_RESYNC: if (rs_hit_i) st_d = ST_DONE;
      ST_DONE:   st_d = ST_LOCKED;
      ST_ERR:    st_d = ST_ERR;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      frz_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ld_fields_o)     frz_q <= 1'b0;
      else if (ld_force_o) frz_q <= 1'b1;
    end
  end

  assign st_o  = st_q;
  assign frz_o = frz_q;

  // R3
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !(coarse_i && fine_i)) |=> (st_q == ST_WAIT || st_q == ST_ERR));

  // R8
  busy_ignore_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START || st_q == ST_WAIT || st_q == ST_ERR) |=> st_q != ST_EN);
endmodule

// File: rtl/dll_lock_seq.sv
`timescale 1ns/1ps
module dll_lock_seq
  import dll_seq_pkg::*;
#(
  parameter int SP_W         = 8,
  parameter int INC_W        = 8,
  parameter int LOCK_W       = 10,
  parameter int LOCK_TIMEOUT = 4096,
  parameter int RESYNC_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              fixed_mode_i,
  input  logic              low_freq_i,
  input  logic [SP_W-1:0]   start_point_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              coarse_lock_i,
  input  logic              fine_lock_i,
  input  logic [LOCK_W-1:0] lock_value_i,
  output logic [SP_W-1:0]   start_point_o,
  output logic [INC_W-1:0]  inc_o,
  output logic              dll_on_o,
  output logic              start_o,
  output logic [LOCK_W-3:0] force_o,
  output logic              resync_o,
  output logic              done_o,
  output logic              error_o
);
  localparam int FORCE_W = LOCK_W - 2;
  localparam int TO_W    = $clog2(LOCK_TIMEOUT + 1);
  localparam int RS_W    = $clog2(RESYNC_CYC + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(LOCK_TIMEOUT - 1);
  localparam logic [RS_W-1:0] RS_LAST = RS_W'(RESYNC_CYC - 1);

  seq_st_e             st;
  logic                frz, ld_fields, ld_force;
  logic [TO_W-1:0]     to_cnt;
  logic [RS_W-1:0]     rs_cnt;
  logic [SP_W-1:0]     sp_q;
  logic [INC_W-1:0]    inc_q;
  logic [FORCE_W-1:0]  force_q;
  logic                in_wait, in_rs;

  assign in_wait = (st == ST_WAIT);
  assign in_rs   = (st == ST_RESYNC);

  dll_seq_cnt #(.W(TO_W)) u_to_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (!in_wait), .en_i (in_wait), .cnt_o (to_cnt)
  );

  dll_seq_cnt #(.W(RS_W)) u_rs_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (!in_rs), .en_i (in_rs), .cnt_o (rs_cnt)
  );

  dll_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go_i),
    .coarse_i    (coarse_lock_i),
    .fine_i      (fine_lock_i),
    .freeze_i    (fixed_mode_i && low_freq_i),
    .to_hit_i    (to_cnt == TO_LAST),
    .rs_hit_i    (rs_cnt == RS_LAST),
    .st_o        (st),
    .frz_o       (frz),
    .ld_fields_o (ld_fields),
    .ld_force_o  (ld_force)
  );

  // control field capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      inc_q   <= '0;
      force_q <= '0;
    end else begin
      if (ld_fields) begin
        sp_q    <= start_point_i;
        inc_q   <= inc_i;
        force_q <= '0;
      end else if (ld_force) begin
        force_q <= lock_value_i[LOCK_W-1:2];
      end
    end
  end

  always_comb begin
    dll_on_o = 1'b0;
    start_o  = 1'b0;
    unique case (st)
      ST_EN:                       dll_on_o = 1'b1;
      ST_START, ST_WAIT, ST_FORCE: begin dll_on_o = 1'b1; start_o = 1'b1; end
      ST_RESYNC, ST_DONE, ST_LOCKED: begin dll_on_o = !frz; start_o = 1'b1; end
      default: ;
    endcase
  end

  assign start_point_o = sp_q;
  assign inc_o         = inc_q;
  assign force_o       = force_q;
  assign resync_o      = in_rs;
  assign done_o        = (st == ST_DONE);
  assign error_o       = (st == ST_ERR);

  // R2
  start_after_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> dll_on_o && $past(dll_on_o));

  // R4
  freeze_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dll_on_o) && !error_o) |-> resync_o && $stable(force_o));

  // R6
  resync_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> (rs_cnt <= RS_LAST));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_after_resync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(resync_o) && !resync_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o && !dll_on_o && !start_o && !resync_o);
endmodule

// File: tb/sim_dll_lock_seq.sv
`timescale 1ns/1ps
module sim_dll_lock_seq;
  localparam int TO = 20;
  localparam int RS = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       go = 1'b0, fixed = 1'b0, lowf = 1'b0;
  logic [7:0] sp_i = '0, inc_i = '0;
  logic       coarse = 1'b0, fine = 1'b0;
  logic [9:0] lv = '0;
  logic [7:0] sp_o, inc_o, force_o;
  logic       dll_on, start, resync, done, err;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dll_lock_seq #(.LOCK_TIMEOUT(TO), .RESYNC_CYC(RS)) u0 (
    .clk_i (clk), .rst_ni (rst_ni), .go_i (go),
    .fixed_mode_i (fixed), .low_freq_i (lowf),
    .start_point_i (sp_i), .inc_i (inc_i),
    .coarse_lock_i (coarse), .fine_lock_i (fine), .lock_value_i (lv),
    .start_point_o (sp_o), .inc_o (inc_o), .dll_on_o (dll_on), .start_o (start),
    .force_o (force_o), .resync_o (resync), .done_o (done), .error_o (err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, {sp_o, inc_o, force_o}, 0);
    chk(req, {dll_on, start, resync, done, err}, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; go = 1'b0; coarse = 1'b0; fine = 1'b0;
    repeat (2) @(negedge clk);
    chk_idle("R10 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R10 after reset");
  endtask

  function automatic int lock_cycle(int cd, int fd);
    int m = (cd > fd) ? cd : fd;
    return (m < 1) ? 1 : m;
  endfunction

  task automatic run_seq(int cd, int fd, bit fx, bit lf, logic [9:0] val,
                         logic [7:0] sp, logic [7:0] inc, bit poke);
    int  lk  = lock_cycle(cd, fd);
    bit  bad = (lk > TO);
    bit  frz = fx && lf;
    logic [7:0] fexp = frz ? val[9:2] : 8'h00;
    @(negedge clk);
    go = 1'b1; sp_i = sp; inc_i = inc; fixed = fx; lowf = lf; lv = val;
    coarse = 1'b0; fine = 1'b0;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    chk("R1 dll_on", dll_on, 1);
    chk("R1 start low", start, 0);
    chk("R1 start point", sp_o, sp);
    chk("R1 inc", inc_o, inc);
    chk("R1 force cleared", force_o, 0);
    if (poke) begin go = 1'b1; sp_i = ~sp; inc_i = ~inc; end
    @(posedge clk);
    @(negedge clk);
    chk("R2 start", start, 1);
    chk("R2 dll_on held", dll_on, 1);
    @(posedge clk);
    for (int j = 1; ; j++) begin
      @(negedge clk);
      go = 1'b0;
      coarse = (j >= cd); fine = (j >= fd);
      chk("R2 wait start", start, 1);
      chk("R2 wait dll_on", dll_on, 1);
      chk("R3 no early resync", resync, 0);
      chk("R8 fields kept", {sp_o, inc_o}, {sp, inc});
      @(posedge clk);
      if (j == lk || j == TO) break;
    end
    if (bad) begin
      @(negedge clk);
      chk("R9 error", err, 1);
      chk("R9 outputs off", {dll_on, start, resync, done}, 0);
      go = 1'b1;
      @(posedge clk);
      @(negedge clk);
      go = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R8 go after error", {err, dll_on, start}, 3'b100);
      do_reset();
      return;
    end
    if (frz) begin
      @(negedge clk);
      chk("R4 force value", force_o, fexp);
      chk("R4 dll_on before drop", dll_on, 1);
      chk("R6 resync not yet", resync, 0);
      @(posedge clk);
    end
    for (int r = 0; r < RS; r++) begin
      @(negedge clk);
      chk("R6 resync high", resync, 1);
      chk("R7 no early done", done, 0);
      chk(frz ? "R4 dll_on off" : "R5 dll_on on", dll_on, !frz);
      chk(frz ? "R4 force held" : "R5 force zero", force_o, fexp);
      @(posedge clk);
    end
    @(negedge clk);
    chk("R7 done", done, 1);
    chk("R6 resync low", resync, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
    chk(frz ? "R4 stays off" : "R5 stays on", dll_on, !frz);
    chk("R5 force final", force_o, fexp);
    chk("R2 start kept", start, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    chk_idle("R10 initial");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R10 idle");
    // directed corners
    run_seq(0, 0, 0, 0, 10'h3FF, 8'h12, 8'h34, 0);     // immediate lock
    run_seq(5, 2, 1, 1, 10'h2B5, 8'hA5, 8'h0F, 1);     // R3 coarse late, freeze, go poked
    run_seq(2, 7, 1, 0, 10'h155, 8'h01, 8'h02, 0);     // R5 fixed without low freq
    run_seq(0, 1, 0, 1, 10'h0F0, 8'h77, 8'h66, 1);     // R5 low freq only
    run_seq(TO, 3, 1, 1, 10'h1C4, 8'h5A, 8'hC3, 0);    // lock on last wait cycle
    run_seq(TO + 1, 0, 0, 0, 10'h000, 8'h11, 8'h22, 0); // R9 timeout
    run_seq(3, 3, 1, 1, 10'h3A8, 8'h99, 8'h88, 0);
    // random mix
    for (int n = 0; n < 40; n++) begin
      int cd = $urandom_range(0, TO + 3);
      int fd = $urandom_range(0, TO + 1);
      run_seq(cd, fd, 1'($urandom), 1'($urandom), 10'($urandom),
              8'($urandom), 8'($urandom), 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule